// File: doc/BRIEF.md
# Intel HEX Record Loader

The loader takes a stream of ASCII characters, one per cycle when `chValid` is high, and parses them as Intel HEX records. Each record begins with a colon and is followed by hexadecimal byte fields: length, address (high byte first), record type, the data bytes and a checksum. It ends with CR or LF. Every byte is added to a running sum, and the data bytes are kept in an internal record buffer.

No memory write happens while a record is still arriving. When the end of line arrives, the length, checksum and type are checked in that order. A data record that passes all three is written out as a burst over a request/acknowledge bus, one write-strobe cycle per byte, with wait states. A record that fails leaves memory untouched and produces a 3-bit error code. After that the loader ignores the input until the next colon.

Top module: `hexld_loader`

## Requirements
- R1: A colon (0x3A) starts a record only when no record is open. A colon inside an open record sets error code 2 (unexpected) and is consumed. A hex digit seen before any colon also gives code 2.
- R2: Space (0x20) and tab (0x09) between byte fields are ignored. Either of them between the two digits of one byte gives code 2.
- R3: Two hex digits (0-9, A-F, a-f), high nibble first, form one byte. A character that is not a hex digit, colon, blank, CR (0x0D) or LF (0x0A) gives code 1 (bad character).
- R4: At end of line the record must hold exactly length+5 bytes, with a length of at most DEPTH (64), and no unpaired digit. Otherwise the code is 5 (bad length). This is checked before the checksum.
- R5: The low 8 bits of the sum of all record bytes, the checksum included, must be 0x00. Otherwise the code is 3 (bad checksum), and nothing is written.
- R6: Type 0x00 writes its data bytes. Type 0x01 (end of file) is accepted with no write. Any other type gives code 4 (bad type). The type is checked after the checksum.
- R7: Data byte i is written to address base+i with byte i on `memData`, in increasing i. The burst holds `busReqN` low and waits for `busAckN` low before the first strobe. `memWrN` is low only while the bus is granted, and it stays low while `memWaitN` is low.
- R8: After an error, `errCode` and `errFlag` hold and all characters other than CR/LF have no effect until a colon. That colon starts a record and clears the code to 0.
- R9: Each CR or LF increments `lineCount` by one and clears `colCount`. Every other accepted character increments `colCount`.
- R10: `busy` is high for the whole write burst. A character presented while `busy` is high is dropped.
- R11: After reset, `busReqN` and `memWrN` are high, `busy` and `errFlag` are low, and `errCode`, `lineCount` and `colCount` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | Character strobe |
| chData | input | 8 | ASCII character |
| busReqN | output | 1 | Active-low bus request |
| busAckN | input | 1 | Active-low bus grant |
| memAddr | output | 16 | Write address |
| memData | output | 8 | Write data |
| memWrN | output | 1 | Active-low write strobe |
| memWaitN | input | 1 | Active-low wait, stretches the strobe |
| busy | output | 1 | Write burst in progress |
| errFlag | output | 1 | Last record rejected |
| errCode | output | 3 | Reason: 0 ok, 1 char, 2 unexpected, 3 checksum, 4 type, 5 length |
| lineCount | output | LINE_W | CR/LF count |
| colCount | output | COL_W | Characters since last CR/LF |

## Verification
The hardest case to reach is a character that arrives in the middle of a committed burst. Once the line ends, the bus has to be owned, and the memory must stall long enough that a character lands while `busy` is high. The bench gets there by delaying the grant and adding wait cycles to every strobe. It then pushes a stray letter without waiting for `busy` to fall, and checks that the error code, the column count and the written bytes show no trace of it. The other hard cases are boundaries built as whole records: a maximum-length record, one byte over the maximum, and a recovery in which the bench sends a bad colon, junk characters and then a clean record.

// File: rtl/hexld_pkg.sv
package hexld_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_CHAR  = 3'd1,
    ERR_UNEXP = 3'd2,
    ERR_SUM   = 3'd3,
    ERR_TYPE  = 3'd4,
    ERR_LEN   = 3'd5
  } errCode_t;

  typedef enum logic [2:0] {
    CC_OTHER,
    CC_HEX,
    CC_BLANK,
    CC_EOL,
    CC_COLON
  } chClass_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_REC,
    ST_WREQ,
    ST_WSTB,
    ST_WHOLD,
    ST_WGAP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     startRec;
    logic     takeNib;
    logic [3:0] nib;
    logic     bumpCol;
    logic     bumpLine;
    logic     setErr;
    errCode_t errVal;
    logic     wrFirst;
    logic     wrAdv;
  } dpCtl_t;

  function automatic chClass_t classify(input logic [7:0] c);
    chClass_t r;
    if (c == 8'h3A)                          r = CC_COLON;
    else if (c == 8'h0D || c == 8'h0A)       r = CC_EOL;
    else if (c == 8'h20 || c == 8'h09)       r = CC_BLANK;
    else if (c >= 8'h30 && c <= 8'h39)       r = CC_HEX;
    else if (c >= 8'h41 && c <= 8'h46)       r = CC_HEX;
    else if (c >= 8'h61 && c <= 8'h66)       r = CC_HEX;
    else                                     r = CC_OTHER;
    return r;
  endfunction

  // low nibble of the character plus 9 maps A-F / a-f onto 10-15
  function automatic logic [3:0] hexVal(input logic [3:0] lo, input logic isDigit);
    return isDigit ? lo : lo + 4'd9;
  endfunction

endpackage

// File: rtl/hexld_dp.sv
module hexld_dp
  import hexld_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 16,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output logic              nibPend,
  output logic              lenOk,
  output logic              sumOk,
  output logic [7:0]        typeVal,
  output logic              lenZero,
  output logic              lastByte,
  output logic [15:0]       memAddr,
  output logic [7:0]        memData,
  output errCode_t          errCode,
  output logic [LINE_W-1:0] lineCount,
  output logic [COL_W-1:0]  colCount
);

  localparam int IW     = $clog2(DEPTH);
  localparam int CNTW   = 9;               // holds 255 + 5 header/trailer bytes
  localparam int HDR    = 4;
  localparam logic [CNTW-1:0] CNT_MAX = '1;

  logic [3:0]      nibHi;
  logic [CNTW-1:0] byteCnt;
  logic [7:0]      sum;
  logic [7:0]      lenReg;
  logic [15:0]     baseAddr;
  logic [IW-1:0]   wIdx;
  logic [7:0]      bufMem [DEPTH];

  logic [7:0]      newByte;
  logic [CNTW-1:0] dataIdx;
  logic            storeData;

  assign newByte   = {nibHi, ctl.nib};
  assign dataIdx   = byteCnt - CNTW'(HDR);
  assign storeData = ctl.takeNib && nibPend && (byteCnt >= CNTW'(HDR))
                     && (dataIdx < CNTW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nibHi     <= '0;
      nibPend   <= 1'b0;
      byteCnt   <= '0;
      sum       <= '0;
      lenReg    <= '0;
      baseAddr  <= '0;
      typeVal   <= '0;
      wIdx      <= '0;
      errCode   <= ERR_NONE;
      lineCount <= '0;
      colCount  <= '0;
    end else begin
      if (ctl.startRec) begin
        nibPend <= 1'b0;
        byteCnt <= '0;
        sum     <= '0;
        errCode <= ERR_NONE;
      end
      if (ctl.takeNib) begin
        if (!nibPend) begin
          nibHi   <= ctl.nib;
          nibPend <= 1'b1;
        end else begin
          nibPend <= 1'b0;
          sum     <= sum + newByte;
          if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
          case (byteCnt)
            CNTW'(0): lenReg         <= newByte;
            CNTW'(1): baseAddr[15:8] <= newByte;
            CNTW'(2): baseAddr[7:0]  <= newByte;
            CNTW'(3): typeVal        <= newByte;
            default: ;
          endcase
        end
      end
      if (ctl.setErr) errCode <= ctl.errVal;
      if (ctl.bumpLine) begin
        lineCount <= lineCount + 1'b1;
        colCount  <= '0;
      end else if (ctl.bumpCol) begin
        colCount <= colCount + 1'b1;
      end
      if (ctl.wrFirst)    wIdx <= '0;
      else if (ctl.wrAdv) wIdx <= wIdx + 1'b1;
    end
  end

  // record buffer, no reset needed
  always_ff @(posedge clk) begin
    if (storeData) bufMem[dataIdx[IW-1:0]] <= newByte;
  end

  assign lenOk    = (lenReg <= 8'(DEPTH)) && (byteCnt == ({1'b0, lenReg} + CNTW'(HDR + 1)));
  assign sumOk    = (sum == 8'h00);
  assign lenZero  = (lenReg == 8'h00);
  assign lastByte = ({{(CNTW-IW){1'b0}}, wIdx} + 1'b1) == {1'b0, lenReg};
  assign memAddr  = baseAddr + {{(16-IW){1'b0}}, wIdx};
  assign memData  = bufMem[wIdx];

endmodule

// File: rtl/hexld_ctrl.sv
module hexld_ctrl
  import hexld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chValid,
  input  logic [7:0] chData,
  input  logic       busAckN,
  input  logic       memWaitN,
  input  logic       nibPend,
  input  logic       lenOk,
  input  logic       sumOk,
  input  logic [7:0] typeVal,
  input  logic       lenZero,
  input  logic       lastByte,
  output dpCtl_t     ctl,
  output logic       busReqN,
  output logic       memWrN,
  output logic       busy
);

  ctlState_t st, nxt;
  chClass_t  cls;
  logic      inBurst;
  logic      take;

  assign cls     = classify(chData);
  assign inBurst = (st == ST_WREQ) || (st == ST_WSTB) || (st == ST_WHOLD) || (st == ST_WGAP);
  assign take    = chValid && !inBurst;

  always_comb begin
    ctl     = '0;
    ctl.nib = hexVal(chData[3:0], chData[6:4] == 3'b011);
    nxt     = st;
    if (take) begin
      ctl.bumpLine = (cls == CC_EOL);
      ctl.bumpCol  = (cls != CC_EOL);
    end
    case (st)
      ST_IDLE: if (take) begin
        case (cls)
          CC_COLON: begin ctl.startRec = 1'b1; nxt = ST_REC; end
          CC_HEX:   begin ctl.setErr = 1'b1; ctl.errVal = ERR_UNEXP; nxt = ST_HUNT; end
          CC_OTHER: begin ctl.setErr = 1'b1; ctl.errVal = ERR_CHAR;  nxt = ST_HUNT; end
          default: ;
        endcase
      end
      ST_HUNT: if (take && cls == CC_COLON) begin
        ctl.startRec = 1'b1;
        nxt = ST_REC;
      end
      ST_REC: if (take) begin
        case (cls)
          CC_HEX:   ctl.takeNib = 1'b1;
          CC_BLANK: if (nibPend) begin
            ctl.setErr = 1'b1; ctl.errVal = ERR_UNEXP; nxt = ST_HUNT;
          end
          CC_COLON: begin ctl.setErr = 1'b1; ctl.errVal = ERR_UNEXP; nxt = ST_HUNT; end
          CC_OTHER: begin ctl.setErr = 1'b1; ctl.errVal = ERR_CHAR;  nxt = ST_HUNT; end
          CC_EOL: begin
            if (nibPend || !lenOk) begin
              ctl.setErr = 1'b1; ctl.errVal = ERR_LEN; nxt = ST_HUNT;
            end else if (!sumOk) begin
              ctl.setErr = 1'b1; ctl.errVal = ERR_SUM; nxt = ST_HUNT;
            end else if (typeVal == 8'h01) begin
              nxt = ST_IDLE;
            end else if (typeVal != 8'h00) begin
              ctl.setErr = 1'b1; ctl.errVal = ERR_TYPE; nxt = ST_HUNT;
            end else if (lenZero) begin
              nxt = ST_IDLE;
            end else begin
              ctl.wrFirst = 1'b1; nxt = ST_WREQ;
            end
          end
          default: ;
        endcase
      end
      ST_WREQ:  if (!busAckN) nxt = ST_WSTB;
      ST_WSTB:  nxt = ST_WHOLD;
      ST_WHOLD: if (memWaitN) nxt = ST_WGAP;
      ST_WGAP: begin
        ctl.wrAdv = 1'b1;
        nxt = lastByte ? ST_IDLE : ST_WSTB;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  assign busReqN = !inBurst;
  assign memWrN  = !((st == ST_WSTB) || (st == ST_WHOLD));
  assign busy    = inBurst;

endmodule

// File: rtl/hexld_loader.sv
module hexld_loader
  import hexld_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 16,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chValid,
  input  logic [7:0]        chData,
  output logic              busReqN,
  input  logic              busAckN,
  output logic [15:0]       memAddr,
  output logic [7:0]        memData,
  output logic              memWrN,
  input  logic              memWaitN,
  output logic              busy,
  output logic              errFlag,
  output logic [2:0]        errCode,
  output logic [LINE_W-1:0] lineCount,
  output logic [COL_W-1:0]  colCount
);

  dpCtl_t   ctl;
  logic     nibPend, lenOk, sumOk, lenZero, lastByte;
  logic [7:0] typeVal;
  errCode_t errReg;

  hexld_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
    .busAckN(busAckN), .memWaitN(memWaitN),
    .nibPend(nibPend), .lenOk(lenOk), .sumOk(sumOk), .typeVal(typeVal),
    .lenZero(lenZero), .lastByte(lastByte),
    .ctl(ctl), .busReqN(busReqN), .memWrN(memWrN), .busy(busy)
  );

  hexld_dp #(.DEPTH(DEPTH), .LINE_W(LINE_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .nibPend(nibPend), .lenOk(lenOk), .sumOk(sumOk), .typeVal(typeVal),
    .lenZero(lenZero), .lastByte(lastByte),
    .memAddr(memAddr), .memData(memData), .errCode(errReg),
    .lineCount(lineCount), .colCount(colCount)
  );

  assign errCode = errReg;
  assign errFlag = (errReg != ERR_NONE);

endmodule

// File: rtl/hexld_chk.sv
module hexld_chk #(
  parameter int LINE_W = 16,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReqN,
  input logic              busAckN,
  input logic              memWrN,
  input logic              memWaitN,
  input logic [15:0]       memAddr,
  input logic              busy,
  input logic [2:0]        errCode,
  input logic [LINE_W-1:0] lineCount,
  input logic [COL_W-1:0]  colCount
);

  a_r7_strobe_granted: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> (!busReqN && !busAckN));

  a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrN && !memWaitN) |=> !memWrN);

  a_r7_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!memWrN && $past(!memWrN)) |-> $stable(memAddr));

  a_r10_req_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    !busReqN |-> busy);

  a_r10_col_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(colCount));

  a_r9_line_step: assert property (@(posedge clk) disable iff (!rstN)
    $stable(lineCount) || (lineCount == $past(lineCount) + 1'b1));

  a_r11_code_range: assert property (@(posedge clk) disable iff (!rstN)
    errCode <= 3'd5);

endmodule

bind hexld_loader hexld_chk #(.LINE_W(LINE_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .busReqN(busReqN), .busAckN(busAckN),
  .memWrN(memWrN), .memWaitN(memWaitN), .memAddr(memAddr), .busy(busy),
  .errCode(errCode), .lineCount(lineCount), .colCount(colCount)
);

// File: tb/sim_hexld_loader.sv
`timescale 1ns/1ps
module sim_hexld_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = 8'h00;
  logic        busReqN, memWrN, busy, errFlag;
  logic        busAckN = 1'b1;
  logic        memWaitN = 1'b1;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic [2:0]  errCode;
  logic [15:0] lineCount;
  logic [7:0]  colCount;

  int nChecks = 0;
  int nFails  = 0;
  int ackDelay = 0;
  int ackCnt = 0;
  int stallSet = 0;
  int stallLeft = 0;
  int nWr = 0;
  logic prevWr = 1'b1;
  logic [15:0] logAddr [128];
  logic [7:0]  logData [128];

  always #2.5 clk = ~clk;

  hexld_loader u0 (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
    .busReqN(busReqN), .busAckN(busAckN), .memAddr(memAddr), .memData(memData),
    .memWrN(memWrN), .memWaitN(memWaitN), .busy(busy), .errFlag(errFlag),
    .errCode(errCode), .lineCount(lineCount), .colCount(colCount)
  );

  // bus and memory model, all on the falling edge
  always @(negedge clk) begin
    if (!busReqN) begin
      if (ackCnt >= ackDelay) busAckN <= 1'b0;
      else ackCnt <= ackCnt + 1;
    end else begin
      busAckN <= 1'b1;
      ackCnt  <= 0;
    end
    if (!memWrN) begin
      if (stallLeft > 0) begin memWaitN <= 1'b0; stallLeft <= stallLeft - 1; end
      else memWaitN <= 1'b1;
    end else begin
      memWaitN  <= 1'b1;
      stallLeft <= stallSet;
    end
    if (prevWr && !memWrN && nWr < 128) begin
      logAddr[nWr] = memAddr;
      logData[nWr] = memData;
      nWr = nWr + 1;
    end
    prevWr <= memWrN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dat(input int seed, input int i);
    return (seed * 7 + i * 37 + 5) & 255;
  endfunction

  // builds one record; nData data bytes are sent, sumDelta corrupts the checksum
  function automatic string recStr(input int len, input int addr, input int typ,
                                   input int seed, input int nData, input bit spaced,
                                   input int sumDelta);
    string s;
    int sum;
    sum = len + ((addr >> 8) & 255) + (addr & 255) + typ;
    s = $sformatf(":%02X%02X%02X%02X", len, (addr >> 8) & 255, addr & 255, typ);
    for (int i = 0; i < nData; i++) begin
      if (spaced) s = {s, (i % 2) ? "\t" : " "};
      s = {s, $sformatf("%02X", dat(seed, i))};
      sum += dat(seed, i);
    end
    if (spaced) s = {s, " "};
    s = {s, $sformatf("%02X", ((256 - (sum & 255)) + sumDelta) & 255)};
    return s;
  endfunction

  task automatic sendChar(input logic [7:0] c);
    @(negedge clk);
    while (busy) @(negedge clk);
    chValid = 1'b1;
    chData  = c;
    @(negedge clk);
    chValid = 1'b0;
  endtask

  task automatic sendStr(input string s);
    for (int i = 0; i < s.len(); i++) sendChar(s[i]);
  endtask

  task automatic waitQuiet();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expectWrites(input int n, input int addr, input int seed, input string req);
    int bad;
    bad = 0;
    check(nWr == n, {req, " write count"}, nWr, n);
    for (int i = 0; i < n && i < nWr; i++)
      if (logAddr[i] != 16'(addr + i) || logData[i] != 8'(dat(seed, i))) bad++;
    check(bad == 0, {req, " write address/data"}, bad, 0);
  endtask

  task automatic expectErr(input int code, input string req);
    check(errCode == 3'(code), {req, " error code"}, errCode, code);
    check(errFlag == (code != 0), {req, " error flag"}, errFlag, code != 0);
  endtask

  task automatic t_reset();
    check(busReqN && memWrN && !busy && !errFlag, "R11 idle outputs",
          {busReqN, memWrN, busy, errFlag}, 4'b1100);
    check(errCode == 0 && lineCount == 0 && colCount == 0, "R11 zero counters",
          errCode + lineCount + colCount, 0);
  endtask

  task automatic t_goodData();
    nWr = 0; ackDelay = 3; stallSet = 2;
    sendStr({recStr(3, 16'h1230, 0, 1, 3, 0, 0), "\r"});
    waitQuiet();
    expectWrites(3, 16'h1230, 1, "R7 R6 plain data record");
    expectErr(0, "R5 good checksum");
  endtask

  task automatic t_spaced();
    nWr = 0; ackDelay = 0; stallSet = 0;
    sendStr({recStr(5, 16'hBEEF, 0, 2, 5, 1, 0), "\n"});
    waitQuiet();
    expectWrites(5, 16'hBEEF, 2, "R2 blanks between bytes");
    expectErr(0, "R2 blanks accepted");
  endtask

  task automatic t_lowerCase();
    string s;
    nWr = 0;
    s = recStr(2, 16'h00AB, 0, 9, 2, 0, 0);
    for (int i = 1; i < s.len(); i++)
      if (s[i] >= "A" && s[i] <= "F") s[i] = s[i] + 8'h20;
    sendStr({s, "\r"});
    waitQuiet();
    expectWrites(2, 16'h00AB, 9, "R3 lower-case digits");
  endtask

  task automatic t_blankInByte();
    nWr = 0;
    sendStr(":0 1");
    waitQuiet();
    expectErr(2, "R2 blank inside byte");
    sendStr("\r");
    check(nWr == 0, "R2 no write", nWr, 0);
  endtask

  task automatic t_badSum();
    nWr = 0; stallSet = 1;
    sendStr({recStr(4, 16'h4000, 0, 3, 4, 0, 1), "\r"});
    waitQuiet();
    expectErr(3, "R5 bad checksum");
    check(nWr == 0, "R5 nothing written", nWr, 0);
  endtask

  task automatic t_badType();
    nWr = 0;
    sendStr({recStr(2, 16'h0010, 2, 4, 2, 0, 0), "\r"});
    waitQuiet();
    expectErr(4, "R6 bad record type");
    check(nWr == 0, "R6 no write on bad type", nWr, 0);
  endtask

  task automatic t_eof();
    nWr = 0;
    sendStr(":00000001FF\r");
    waitQuiet();
    expectErr(0, "R6 end-of-file record");
    check(nWr == 0, "R6 end of file writes nothing", nWr, 0);
  endtask

  task automatic t_lenMismatch();
    nWr = 0;
    sendStr({recStr(4, 16'h2000, 0, 5, 3, 0, 0), "\r"});
    waitQuiet();
    expectErr(5, "R4 short record");
    check(nWr == 0, "R4 no write", nWr, 0);
    sendStr(":0\r");
    waitQuiet();
    expectErr(5, "R4 unpaired digit");
  endtask

  task automatic t_maxLen();
    nWr = 0;
    sendStr({recStr(64, 16'h8000, 0, 6, 64, 0, 0), "\r"});
    waitQuiet();
    expectWrites(64, 16'h8000, 6, "R4 maximum length");
    nWr = 0;
    sendStr({recStr(65, 16'h9000, 0, 7, 65, 0, 0), "\r"});
    waitQuiet();
    expectErr(5, "R4 over maximum length");
    check(nWr == 0, "R4 over maximum writes nothing", nWr, 0);
  endtask

  task automatic t_badChar();
    sendStr(":0G");
    waitQuiet();
    expectErr(1, "R3 bad character");
    check(colCount == 3, "R9 column count", colCount, 3);
    sendStr("\r");
  endtask

  task automatic t_recover();
    nWr = 0;
    sendStr(":0102:");
    waitQuiet();
    expectErr(2, "R1 colon inside record");
    sendStr("1234XY 9");
    waitQuiet();
    expectErr(2, "R8 junk ignored, code held");
    sendStr("\r");
    check(nWr == 0, "R8 no write while hunting", nWr, 0);
    sendStr("5");
    waitQuiet();
    expectErr(2, "R1 digit before colon");
    sendStr({recStr(1, 16'h0500, 0, 8, 1, 0, 0), "\r"});
    waitQuiet();
    expectErr(0, "R8 colon clears error");
    expectWrites(1, 16'h0500, 8, "R8 recovered record");
  endtask

  task automatic t_lines();
    int base;
    base = lineCount;
    sendStr("\r\n");
    waitQuiet();
    check(lineCount == 16'(base + 2), "R9 line per CR and LF", lineCount, base + 2);
    check(colCount == 0, "R9 column cleared", colCount, 0);
  endtask

  task automatic t_busyDrop();
    nWr = 0; ackDelay = 4; stallSet = 3;
    sendStr({recStr(4, 16'h7000, 0, 10, 4, 0, 0), "\r"});
    @(negedge clk);
    check(busy == 1'b1, "R10 busy during burst", busy, 1);
    chValid = 1'b1; chData = "Q";
    @(negedge clk);
    chValid = 1'b0;
    waitQuiet();
    expectErr(0, "R10 dropped char has no effect");
    check(colCount == 0, "R10 column unchanged", colCount, 0);
    expectWrites(4, 16'h7000, 10, "R10 burst intact");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_goodData();
    t_spaced();
    t_lowerCase();
    t_blankInByte();
    t_badSum();
    t_badType();
    t_eof();
    t_lenMismatch();
    t_maxLen();
    t_badChar();
    t_recover();
    t_lines();
    t_busyDrop();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule